// File: doc/BRIEF.md
# Packet Statistics and Test Register Slave

This block is a small AXI4-Lite slave with six 32-bit word registers, placed next to a packet arbiter. Software reads a fixed identifier and a version word from it. Software also reads two live packet counters, which increment on single-cycle pulses from the arbiter's ingress and egress sides. Two scratch registers test the register path. One returns the two's complement of what was stored. The other returns the stored word plus a build-time constant. A read can therefore never pass just by echoing the bus.

The write address and write data channels are captured independently. Each has its own one-entry holding register, so they may arrive in either order or together. A write is committed once both channels are held, and a single response follows. Reads take one handshake and return registered data with OKAY, or with SLVERR for offsets that are not mapped.

Top module: `pktstat_csr`

## Requirements
- R1: After rst_ni is released, bvalid_o and rvalid_o are low, awready_o, wready_o and arready_o are high, both counters read 0, the negation register reads 0 and the debug register reads DBG_ADD.
- R2: A read of byte offset 0x00 returns the parameter ID_VAL and a read of 0x04 returns VER_VAL, both with rresp 2'b00 (OKAY).
- R3: A read of offset 0x08 returns the 32-bit two's complement negation (modulo 2^32) of the word stored there by earlier writes.
- R4: A read of offset 0x14 returns the word stored there plus DBG_ADD, wrapping modulo 2^32.
- R5: On writes to 0x08 and 0x14, byte lane b (bits 8b+7..8b) is updated only when wstrb_i[b] is 1. Lanes with strobe 0 keep their old contents.
- R6: Offset 0x0C reads the number of cycles in which pkt_in_i was high, and offset 0x10 does the same for pkt_out_i. Both counters count in the same cycle when both inputs are high. Each is CNT_W bits wide, zero-extended to 32 bits, and wraps to 0 after 2^CNT_W - 1.
- R7: Writes to 0x00, 0x04, 0x0C and 0x10 get bresp 2'b00 (OKAY) and change nothing that can be read.
- R8: Any offset whose word index is 6 or above, or whose two low address bits are nonzero, is unmapped. An access to it gets response 2'b10 (SLVERR), a read of it returns 0, and a write to it changes nothing.
- R9: The write address and write data may be accepted in either order. bvalid_o rises only after both have been accepted. After a channel has accepted one beat, its ready stays low until the write response is taken.
- R10: While bvalid_o or rvalid_o is high and its ready input is low, the valid stays high and its response and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | ADDR_W | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte strobes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | ADDR_W | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| pkt_in_i | input | 1 | Ingress packet pulse |
| pkt_out_i | input | 1 | Egress packet pulse |

## Verification
A wrong channel holding state shows up at the ports within a few cycles. It appears as a response raised before both write halves were taken, as a ready that reopens too early, or as a write that never completes and stalls the bus. Corrupted storage or a wrong lane merge becomes visible on the next read of the same offset. The negation and the added constant change every stored value, so a stuck or echoed path cannot read back correctly. A counter that miscounts or fails to wrap is caught by reading it after a known pulse count that runs past the counter's width.

// File: rtl/pktstat_pkg.sv
package pktstat_pkg;
  localparam int DATA_W   = 32;
  localparam int STRB_W   = DATA_W / 8;
  localparam int NUM_REGS = 6;
  localparam int NUM_CNT  = 2;

  // word indices; software depends on this layout
  localparam int IDX_ID   = 0;
  localparam int IDX_VER  = 1;
  localparam int IDX_NEG  = 2;
  localparam int IDX_CIN  = 3;
  localparam int IDX_COUT = 4;
  localparam int IDX_DBG  = 5;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/pktstat_cnt.sv
module pktstat_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (inc_i) count_o <= count_o + W'(1);
  end
endmodule

// File: rtl/pktstat_wr_chan.sv
module pktstat_wr_chan
  import pktstat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] cmt_addr_o,
  output logic [DATA_W-1:0] cmt_data_o,
  output logic [STRB_W-1:0] cmt_strb_o,
  input  logic              cmt_err_i
);
  logic aw_full_q, w_full_q;

  assign awready_o = !aw_full_q && !bvalid_o;
  assign wready_o  = !w_full_q && !bvalid_o;
  assign commit_o  = aw_full_q && w_full_q && !bvalid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q  <= 1'b0;
      w_full_q   <= 1'b0;
      cmt_addr_o <= '0;
      cmt_data_o <= '0;
      cmt_strb_o <= '0;
      bvalid_o   <= 1'b0;
      bresp_o    <= RESP_OKAY;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_full_q  <= 1'b1;
        cmt_addr_o <= awaddr_i;
      end
      if (wvalid_i && wready_o) begin
        w_full_q   <= 1'b1;
        cmt_data_o <= wdata_i;
        cmt_strb_o <= wstrb_i;
      end
      if (commit_o) begin
        aw_full_q <= 1'b0;
        w_full_q  <= 1'b0;
        bvalid_o  <= 1'b1;
        bresp_o   <= cmt_err_i ? RESP_SLVERR : RESP_OKAY;
      end else if (bvalid_o && bready_i) begin
        bvalid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pktstat_rd_chan.sv
module pktstat_rd_chan
  import pktstat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic [DATA_W-1:0] lk_data_i,
  input  logic              lk_err_i
);
  assign arready_o = !rvalid_o;
  assign lk_addr_o = araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      rresp_o  <= RESP_OKAY;
    end else if (arvalid_i && arready_o) begin
      rvalid_o <= 1'b1;
      rdata_o  <= lk_err_i ? '0 : lk_data_i;
      rresp_o  <= lk_err_i ? RESP_SLVERR : RESP_OKAY;
    end else if (rvalid_o && rready_i) begin
      rvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pktstat_regs.sv
module pktstat_regs
  import pktstat_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] ID_VAL  = 32'h0000_A5B6,
  parameter logic [31:0] VER_VAL = 32'h0001_0000,
  parameter logic [31:0] DBG_ADD = 32'h1000_0001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [STRB_W-1:0]  wr_strb_i,
  output logic               wr_err_o,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_err_o,
  input  logic [NUM_CNT-1:0] inc_i
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] neg_q, dbg_q;
  logic [CNT_W-1:0]  cnt [NUM_CNT];

  assign wr_idx   = wr_addr_i[ADDR_W-1:2];
  assign rd_idx   = rd_addr_i[ADDR_W-1:2];
  assign wr_err_o = (wr_addr_i[1:0] != 2'b00) || (wr_idx >= IDX_W'(NUM_REGS));
  assign rd_err_o = (rd_addr_i[1:0] != 2'b00) || (rd_idx >= IDX_W'(NUM_REGS));

  // raw storage; transforms are applied on the read path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= '0;
      dbg_q <= '0;
    end else if (wr_en_i && !wr_err_o) begin
      for (int b = 0; b < STRB_W; b++) begin
        if (wr_strb_i[b]) begin
          if (wr_idx == IDX_W'(IDX_NEG)) neg_q[b*8 +: 8] <= wr_data_i[b*8 +: 8];
          if (wr_idx == IDX_W'(IDX_DBG)) dbg_q[b*8 +: 8] <= wr_data_i[b*8 +: 8];
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    pktstat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc_i[c]),
      .count_o(cnt[c])
    );
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_idx)
      IDX_W'(IDX_ID):   rd_data_o = ID_VAL;
      IDX_W'(IDX_VER):  rd_data_o = VER_VAL;
      IDX_W'(IDX_NEG):  rd_data_o = -neg_q;
      IDX_W'(IDX_CIN):  rd_data_o = DATA_W'(cnt[0]);
      IDX_W'(IDX_COUT): rd_data_o = DATA_W'(cnt[1]);
      IDX_W'(IDX_DBG):  rd_data_o = dbg_q + DBG_ADD;
      default:          rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pktstat_csr.sv
module pktstat_csr
  import pktstat_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] ID_VAL  = 32'h0000_A5B6,
  parameter logic [31:0] VER_VAL = 32'h0001_0000,
  parameter logic [31:0] DBG_ADD = 32'h1000_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic              pkt_in_i,
  input  logic              pkt_out_i
);
  logic              commit, cmt_err, lk_err;
  logic [ADDR_W-1:0] cmt_addr, lk_addr;
  logic [DATA_W-1:0] cmt_data, lk_data;
  logic [STRB_W-1:0] cmt_strb;

  pktstat_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bresp_o, .bvalid_o, .bready_i,
    .commit_o  (commit),
    .cmt_addr_o(cmt_addr),
    .cmt_data_o(cmt_data),
    .cmt_strb_o(cmt_strb),
    .cmt_err_i (cmt_err)
  );

  pktstat_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni,
    .araddr_i, .arvalid_i, .arready_o,
    .rdata_o, .rresp_o, .rvalid_o, .rready_i,
    .lk_addr_o(lk_addr),
    .lk_data_i(lk_data),
    .lk_err_i (lk_err)
  );

  pktstat_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .ID_VAL(ID_VAL), .VER_VAL(VER_VAL), .DBG_ADD(DBG_ADD)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i  (commit),
    .wr_addr_i(cmt_addr),
    .wr_data_i(cmt_data),
    .wr_strb_i(cmt_strb),
    .wr_err_o (cmt_err),
    .rd_addr_i(lk_addr),
    .rd_data_o(lk_data),
    .rd_err_o (lk_err),
    .inc_i    ({pkt_out_i, pkt_in_i})
  );
endmodule

// File: rtl/pktstat_csr_chk.sv
module pktstat_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        awvalid_i,
  input logic        awready_o,
  input logic        wvalid_i,
  input logic        wready_o,
  input logic [1:0]  bresp_o,
  input logic        bvalid_o,
  input logic        bready_i,
  input logic [31:0] rdata_o,
  input logic [1:0]  rresp_o,
  input logic        rvalid_o,
  input logic        rready_i
);
  logic aw_seen_q, w_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_seen_q <= 1'b0;
      w_seen_q  <= 1'b0;
    end else if (bvalid_o && bready_i) begin
      aw_seen_q <= 1'b0;
      w_seen_q  <= 1'b0;
    end else begin
      if (awvalid_i && awready_o) aw_seen_q <= 1'b1;
      if (wvalid_i && wready_o)   w_seen_q  <= 1'b1;
    end
  end

  p_b_needs_both_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bvalid_o) |-> aw_seen_q && w_seen_q);
  p_aw_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_seen_q |-> !awready_o);
  p_w_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_seen_q |-> !wready_o);
  p_b_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o && $stable(bresp_o));
  p_r_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o) && $stable(rresp_o));
  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && rresp_o == 2'b10 |-> rdata_o == 32'h0);
endmodule

bind pktstat_csr pktstat_csr_chk u_chk (.*);

// File: tb/pktstat_csr_tb_top.sv
`timescale 1ns/1ps
module pktstat_csr_tb_top;
  localparam logic [31:0] ID_V  = 32'h0000_A5B6;
  localparam logic [31:0] VER_V = 32'h0001_0000;
  localparam logic [31:0] ADD_V = 32'h1000_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        pkt_in = 0, pkt_out = 0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pktstat_csr #(.ADDR_W(8), .CNT_W(8), .ID_VAL(ID_V), .VER_VAL(VER_V), .DBG_ADD(ADD_V)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .awaddr_i(awaddr), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wvalid_i(wvalid), .wready_o(wready),
    .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .araddr_i(araddr), .arvalid_i(arvalid), .arready_o(arready),
    .rdata_o(rdata), .rresp_o(rresp), .rvalid_o(rvalid), .rready_i(rready),
    .pkt_in_i(pkt_in), .pkt_out_i(pkt_out)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [1:0]  bresp;
    logic [1:0]  rresp;
    logic [31:0] rdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,         4'hF, 2'b00, 2'b00, 32'h0000_A5B6, 4'd2}, // R2
    '{1'b0, 8'h04, 32'h0,         4'hF, 2'b00, 2'b00, 32'h0001_0000, 4'd2}, // R2
    '{1'b1, 8'h08, 32'h0000_0005, 4'hF, 2'b00, 2'b00, 32'hFFFF_FFFB, 4'd3}, // R3
    '{1'b1, 8'h14, 32'h0000_00FF, 4'hF, 2'b00, 2'b00, 32'h1000_0100, 4'd4}, // R4
    '{1'b1, 8'h14, 32'hFFFF_FFFF, 4'hF, 2'b00, 2'b00, 32'h1000_0000, 4'd4}, // R4 wrap
    '{1'b1, 8'h08, 32'h8000_0000, 4'hF, 2'b00, 2'b00, 32'h8000_0000, 4'd3}, // R3
    '{1'b1, 8'h08, 32'hAABB_CCDD, 4'h1, 2'b00, 2'b00, 32'h7FFF_FF23, 4'd5}, // R5
    '{1'b1, 8'h00, 32'h0,         4'hF, 2'b00, 2'b00, 32'h0000_A5B6, 4'd7}, // R7
    '{1'b1, 8'h0C, 32'h0000_0055, 4'hF, 2'b00, 2'b00, 32'h0,         4'd7}, // R7
    '{1'b1, 8'h18, 32'h1234_5678, 4'hF, 2'b10, 2'b10, 32'h0,         4'd8}, // R8
    '{1'b1, 8'h09, 32'h1234_5678, 4'hF, 2'b10, 2'b10, 32'h0,         4'd8}, // R8
    '{1'b1, 8'h14, 32'h0,         4'h8, 2'b00, 2'b00, 32'h1100_0000, 4'd5}  // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all driving and sampling at the falling edge
  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int aw_dly, input int w_dly, input int b_dly,
                          output logic [1:0] resp, output logic early, output logic hold_bad);
    bit aw_done = 0, w_done = 0, hs_aw, hs_w;
    int k = 0;
    early = 0; hold_bad = 0;
    awaddr = a; wdata = d; wstrb = s;
    while (!(aw_done && w_done)) begin
      if (!aw_done && k >= aw_dly) awvalid = 1;
      if (!w_done && k >= w_dly) wvalid = 1;
      if (bvalid) early = 1;
      hs_aw = awvalid && awready;
      hs_w  = wvalid && wready;
      @(negedge clk);
      if (hs_aw) begin awvalid = 0; aw_done = 1; end
      if (hs_w)  begin wvalid = 0; w_done = 1; end
      k++;
    end
    while (!bvalid) @(negedge clk);
    resp = bresp;
    for (int i = 0; i < b_dly; i++) begin
      @(negedge clk);
      if (!bvalid || bresp !== resp) hold_bad = 1;
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic do_read(input logic [7:0] a, input int r_dly,
                         output logic [31:0] d, output logic [1:0] resp, output logic hold_bad);
    bit hs;
    hold_bad = 0;
    araddr = a; arvalid = 1;
    hs = 0;
    while (!hs) begin
      hs = arready;
      @(negedge clk);
    end
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    d = rdata; resp = rresp;
    for (int i = 0; i < r_dly; i++) begin
      @(negedge clk);
      if (!rvalid || rdata !== d || rresp !== resp) hold_bad = 1;
    end
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  initial begin
    logic [31:0] d;
    logic [1:0]  rs, bs;
    logic        early, hb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 awready", 32'(awready), 32'd1);
    chk("R1 wready",  32'(wready),  32'd1);
    chk("R1 arready", 32'(arready), 32'd1);
    chk("R1 valids",  {30'd0, bvalid, rvalid}, 32'd0);
    do_read(8'h08, 0, d, rs, hb); chk("R1 neg reg", d, 32'h0);
    do_read(8'h14, 0, d, rs, hb); chk("R1 dbg reg", d, ADD_V);
    do_read(8'h0C, 0, d, rs, hb); chk("R1 cnt in",  d, 32'h0);
    do_read(8'h10, 0, d, rs, hb); chk("R1 cnt out", d, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].wr) begin
        do_write(VECS[i].addr, VECS[i].data, VECS[i].strb, 0, 0, 0, bs, early, hb);
        chk({tag, " bresp"}, 32'(bs), 32'(VECS[i].bresp));
      end
      do_read(VECS[i].addr, 0, d, rs, hb);
      chk({tag, " rresp"}, 32'(rs), 32'(VECS[i].rresp));
      chk({tag, " rdata"}, d, VECS[i].rdata);
    end
    // R8 unmapped write left neighbours unchanged
    do_read(8'h14, 0, d, rs, hb); chk("R8 dbg intact", d, 32'h1100_0000);
    do_read(8'hFC, 0, d, rs, hb); chk("R8 high read resp", 32'(rs), 32'd2);
    chk("R8 high read data", d, 32'h0);

    // R9 data before address, with delayed bready for R10
    do_write(8'h14, 32'h0000_0010, 4'hF, 4, 0, 3, bs, early, hb);
    chk("R9 w-first early bvalid", 32'(early), 32'd0);
    chk("R10 bvalid hold", 32'(hb), 32'd0);
    do_read(8'h14, 0, d, rs, hb); chk("R9 w-first data", d, 32'h1000_0011);
    // R9 address before data
    do_write(8'h08, 32'h0000_0001, 4'hF, 0, 4, 0, bs, early, hb);
    chk("R9 aw-first early bvalid", 32'(early), 32'd0);
    do_read(8'h08, 0, d, rs, hb); chk("R9 aw-first data", d, 32'hFFFF_FFFF);

    // R10 read stall
    do_read(8'h00, 4, d, rs, hb);
    chk("R10 rvalid hold", 32'(hb), 32'd0);
    chk("R10 stalled data", d, ID_V);

    // R6 counters: 300 in pulses (wraps at 256), 5 out pulses overlapping
    pkt_in = 1; pkt_out = 1;
    for (int i = 0; i < 300; i++) begin
      if (i == 5) pkt_out = 0;
      @(negedge clk);
    end
    pkt_in = 0;
    do_read(8'h0C, 0, d, rs, hb); chk("R6 in count wrap", d, 32'd44);
    do_read(8'h10, 0, d, rs, hb); chk("R6 out count", d, 32'd5);
    // R7 write to counter ignored
    do_write(8'h10, 32'hFFFF_0000, 4'hF, 0, 0, 0, bs, early, hb);
    chk("R7 cnt write resp", 32'(bs), 32'd0);
    do_read(8'h10, 0, d, rs, hb); chk("R7 cnt unchanged", d, 32'd5);
    do_write(8'h04, 32'h0, 4'hF, 0, 0, 0, bs, early, hb);
    do_read(8'h04, 0, d, rs, hb); chk("R7 ver unchanged", d, VER_V);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule